// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block takes the attributes gathered by a page-table walk and decides whether a memory access may proceed. The inputs are the combined user, writable and no-execute attributes, the protection key of the leaf entry, the privilege level and type of the access, and the paging mode controls. The two key registers, one for user pages and one for supervisor pages, also arrive as inputs. From these the block computes read, write and execute permissions for the page and checks the requested access against them.

A denied access carries one of two causes. The first is a key violation, where the protection-key rights alone do not cover the request. The second is an ordinary protection violation. The mode controls are supervisor read prevention on user pages, supervisor execute prevention on user pages, write-protect enforcement, and an enable for each of the two key registers. The verdict is registered. It appears one clock after the request and is qualified by a response valid.

Top module: `pkey_perm_eval`

## Requirements
- R1: A user access (`is_user`=1) to a page whose combined user attribute is 0 gives `fault_prot`=1, `fault_key`=0, `allowed`=0 and all three permission outputs 0. The key rights are not consulted.
- R2: `perm_rd` is 1 unless the access is supervisor, `rd_prevent`=1 and the page user attribute is 1. The key rights may also clear it (R6).
- R3: `perm_wr` needs read permission and either the page write attribute or a supervisor access with `wp_en`=0. The key rights may also clear it (R6).
- R4: `perm_ex` is 1 only when the no-execute attribute is 0. For a supervisor access with `ex_prevent`=1, the page user attribute must also be 0.
- R5: A user page (user attribute 1) takes its rights from `ukey_reg` when `ukey_en`=1. A supervisor page takes them from `skey_reg` when `skey_en`=1. In all other cases the key register value is zero and removes nothing.
- R6: For key k, register bit 2k disables access and removes read and write. Bit 2k+1 disables writes and removes write only for a user access or when `wp_en`=1. Execute is never removed by a key.
- R7: If the key register in use is non-zero and its rights lack the requested access, `fault_key`=1 and `fault_prot`=0, even when the page permissions would also deny the access. At most one of `fault_key` and `fault_prot` is 1, and neither is 1 when `allowed`=1.
- R8: `acc_type` encodes load=0, store=1, fetch=2. Code 3 is treated as a fetch. A fetch never produces `fault_key`.
- R9: The permission outputs are the bitwise AND of the page and key permissions. The bit order is read=bit0, write=bit1, execute=bit2, matching the access codes. `allowed`=1 exactly when the bit of the requested access is set. Otherwise `fault_prot`=1, unless R7 applies.
- R10: All outputs are registered. A request sampled with `req_valid`=1 at a rising edge gives `rsp_valid`=1 and its verdict after that edge. Without a request, every output is 0 after the edge. Reset (`rst`, synchronous, active high) clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| attr_user | input | 1 | Combined user attribute of the walk |
| attr_write | input | 1 | Combined writable attribute |
| attr_nx | input | 1 | Combined no-execute attribute |
| pkey | input | KEY_W | Protection key of the leaf entry |
| is_user | input | 1 | Access made at user privilege |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 as fetch |
| rd_prevent | input | 1 | Supervisor read prevention on user pages |
| ex_prevent | input | 1 | Supervisor execute prevention on user pages |
| wp_en | input | 1 | Write-protect enforcement |
| ukey_en | input | 1 | Enable the user-page key register |
| skey_en | input | 1 | Enable the supervisor-page key register |
| ukey_reg | input | 2*NKEYS | User-page key rights |
| skey_reg | input | 2*NKEYS | Supervisor-page key rights |
| rsp_valid | output | 1 | Verdict valid |
| perm_rd | output | 1 | Final read permission |
| perm_wr | output | 1 | Final write permission |
| perm_ex | output | 1 | Final execute permission |
| allowed | output | 1 | Requested access permitted |
| fault_key | output | 1 | Denied by protection key |
| fault_prot | output | 1 | Denied by page protection |

## Verification
A key denial and a page denial can apply to the same request, and the key cause must win. The bench provokes this with a store to a read-only user page whose key has write-disable set, and with a supervisor load under read prevention whose key has access-disable set. It then checks that only `fault_key` rises. Write-protect enforcement acts on both the page write rule and the key write-disable rule in the same cycle. Requests that toggle `wp_en` while holding everything else are compared against a behavioural reference on every clock.

// File: rtl/perm_pkg.sv
package perm_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    // bit0 read, bit1 write, bit2 execute
    typedef struct packed {
        logic ex;
        logic wr;
        logic rd;
    } perm_t;

    typedef struct packed {
        perm_t perm;
        logic  allowed;
        logic  fault_key;
        logic  fault_prot;
    } verdict_t;

    localparam perm_t PERM_NONE = '{ex: 1'b0, wr: 1'b0, rd: 1'b0};
    localparam perm_t PERM_ALL  = '{ex: 1'b1, wr: 1'b1, rd: 1'b1};

    function automatic perm_t acc_mask(input logic [1:0] acc);
        perm_t m;
        m = PERM_NONE;
        case (acc)
            ACC_LOAD:  m.rd = 1'b1;
            ACC_STORE: m.wr = 1'b1;
            default:   m.ex = 1'b1;
        endcase
        return m;
    endfunction

    function automatic logic is_fetch(input logic [1:0] acc);
        return acc[1];
    endfunction

endpackage

// File: rtl/page_perm_calc.sv
module page_perm_calc
    import perm_pkg::*;
(
    input  logic  attr_user,
    input  logic  attr_write,
    input  logic  attr_nx,
    input  logic  is_user,
    input  logic  rd_prevent,
    input  logic  ex_prevent,
    input  logic  wp_en,
    output perm_t page_perm,
    output logic  user_viol
);
    logic sup;
    logic rd_ok;

    always_comb begin
        sup          = ~is_user;
        user_viol    = is_user & ~attr_user;
        rd_ok        = ~(sup & rd_prevent & attr_user);
        page_perm.rd = rd_ok;
        page_perm.wr = rd_ok & (attr_write | (sup & ~wp_en));
        page_perm.ex = ~attr_nx & (is_user | ~(ex_prevent & attr_user));
    end
endmodule

// File: rtl/key_perm_calc.sv
module key_perm_calc
    import perm_pkg::*;
#(
    parameter int NKEYS = 16,
    localparam int KEY_W = $clog2(NKEYS),
    localparam int REG_W = 2 * NKEYS
) (
    input  logic [KEY_W-1:0] pkey,
    input  logic             attr_user,
    input  logic             is_user,
    input  logic             wp_en,
    input  logic             ukey_en,
    input  logic             skey_en,
    input  logic [REG_W-1:0] ukey_reg,
    input  logic [REG_W-1:0] skey_reg,
    output perm_t            key_perm,
    output logic             key_active
);
    logic [REG_W-1:0] sel_reg;
    logic [NKEYS-1:0] ad_bits;
    logic [NKEYS-1:0] wd_bits;
    logic             ad;
    logic             wd;

    always_comb begin
        if (attr_user) sel_reg = ukey_en ? ukey_reg : '0;
        else           sel_reg = skey_en ? skey_reg : '0;
    end

    for (genvar k = 0; k < NKEYS; k++) begin : g_split
        assign ad_bits[k] = sel_reg[2*k];
        assign wd_bits[k] = sel_reg[2*k+1];
    end

    always_comb begin
        key_active = |sel_reg;
        ad         = ad_bits[pkey];
        wd         = wd_bits[pkey];
        key_perm   = PERM_ALL;
        if (ad) begin
            key_perm.rd = 1'b0;
            key_perm.wr = 1'b0;
        end else if (wd && (is_user || wp_en)) begin
            key_perm.wr = 1'b0;
        end
    end
endmodule

// File: rtl/access_decider.sv
module access_decider
    import perm_pkg::*;
(
    input  perm_t      page_perm,
    input  perm_t      key_perm,
    input  logic       key_active,
    input  logic       user_viol,
    input  logic [1:0] acc_type,
    output verdict_t   verdict
);
    perm_t req;
    perm_t merged;
    logic  key_deny;
    logic  hit;

    always_comb begin
        req      = acc_mask(acc_type);
        merged   = page_perm & key_perm;
        key_deny = key_active & ~is_fetch(acc_type) & ~|(key_perm & req);
        hit      = |(merged & req);
        verdict  = '0;
        if (user_viol) begin
            verdict.perm       = PERM_NONE;
            verdict.fault_prot = 1'b1;
        end else if (key_deny) begin
            verdict.perm      = merged;
            verdict.fault_key = 1'b1;
        end else begin
            verdict.perm       = merged;
            verdict.allowed    = hit;
            verdict.fault_prot = ~hit;
        end
    end
endmodule

// File: rtl/pkey_perm_eval.sv
module pkey_perm_eval
    import perm_pkg::*;
#(
    parameter int NKEYS = 16,
    localparam int KEY_W = $clog2(NKEYS),
    localparam int REG_W = 2 * NKEYS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             attr_user,
    input  logic             attr_write,
    input  logic             attr_nx,
    input  logic [KEY_W-1:0] pkey,
    input  logic             is_user,
    input  logic [1:0]       acc_type,
    input  logic             rd_prevent,
    input  logic             ex_prevent,
    input  logic             wp_en,
    input  logic             ukey_en,
    input  logic             skey_en,
    input  logic [REG_W-1:0] ukey_reg,
    input  logic [REG_W-1:0] skey_reg,
    output logic             rsp_valid,
    output logic             perm_rd,
    output logic             perm_wr,
    output logic             perm_ex,
    output logic             allowed,
    output logic             fault_key,
    output logic             fault_prot
);
    perm_t    page_perm;
    perm_t    key_perm;
    logic     user_viol;
    logic     key_active;
    verdict_t verdict;
    verdict_t verdict_q;
    logic     valid_q;

    page_perm_calc u_page (
        .attr_user (attr_user),
        .attr_write(attr_write),
        .attr_nx   (attr_nx),
        .is_user   (is_user),
        .rd_prevent(rd_prevent),
        .ex_prevent(ex_prevent),
        .wp_en     (wp_en),
        .page_perm (page_perm),
        .user_viol (user_viol)
    );

    key_perm_calc #(.NKEYS(NKEYS)) u_key (
        .pkey      (pkey),
        .attr_user (attr_user),
        .is_user   (is_user),
        .wp_en     (wp_en),
        .ukey_en   (ukey_en),
        .skey_en   (skey_en),
        .ukey_reg  (ukey_reg),
        .skey_reg  (skey_reg),
        .key_perm  (key_perm),
        .key_active(key_active)
    );

    access_decider u_dec (
        .page_perm (page_perm),
        .key_perm  (key_perm),
        .key_active(key_active),
        .user_viol (user_viol),
        .acc_type  (acc_type),
        .verdict   (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            verdict_q <= '0;
        end else begin
            valid_q   <= req_valid;
            verdict_q <= req_valid ? verdict : '0;
        end
    end

    assign rsp_valid  = valid_q;
    assign perm_rd    = verdict_q.perm.rd;
    assign perm_wr    = verdict_q.perm.wr;
    assign perm_ex    = verdict_q.perm.ex;
    assign allowed    = verdict_q.allowed;
    assign fault_key  = verdict_q.fault_key;
    assign fault_prot = verdict_q.fault_prot;
endmodule

// File: rtl/pkey_perm_eval_chk.sv
module pkey_perm_eval_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       attr_user,
    input logic       is_user,
    input logic [1:0] acc_type,
    input logic       rsp_valid,
    input logic       perm_rd,
    input logic       perm_wr,
    input logic       perm_ex,
    input logic       allowed,
    input logic       fault_key,
    input logic       fault_prot
);
    p_user_viol_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_user && !attr_user) |=>
            (fault_prot && !fault_key && !allowed && !perm_rd && !perm_wr && !perm_ex));

    p_one_fault_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fault_key, fault_prot, allowed}));

    p_no_key_fetch_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && acc_type[1]) |=> !fault_key);

    p_store_needs_wr_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && acc_type == 2'd1) |=> (allowed == perm_wr || fault_key));

    p_load_needs_rd_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && acc_type == 2'd0) |=> (allowed == perm_rd || fault_key));

    p_resp_valid_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !allowed && !fault_key && !fault_prot));
endmodule

bind pkey_perm_eval pkey_perm_eval_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .attr_user (attr_user),
    .is_user   (is_user),
    .acc_type  (acc_type),
    .rsp_valid (rsp_valid),
    .perm_rd   (perm_rd),
    .perm_wr   (perm_wr),
    .perm_ex   (perm_ex),
    .allowed   (allowed),
    .fault_key (fault_key),
    .fault_prot(fault_prot)
);

// File: tb/pkey_perm_eval_tb.sv
module pkey_perm_eval_tb;
    localparam int NKEYS = 16;
    localparam int KEY_W = $clog2(NKEYS);
    localparam int REG_W = 2 * NKEYS;

    logic clk = 1'b0;
    logic rst;
    logic req_valid, attr_user, attr_write, attr_nx, is_user;
    logic [KEY_W-1:0] pkey;
    logic [1:0] acc_type;
    logic rd_prevent, ex_prevent, wp_en, ukey_en, skey_en;
    logic [REG_W-1:0] ukey_reg, skey_reg;
    logic rsp_valid, perm_rd, perm_wr, perm_ex, allowed, fault_key, fault_prot;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    pkey_perm_eval #(.NKEYS(NKEYS)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .attr_user(attr_user), .attr_write(attr_write), .attr_nx(attr_nx),
        .pkey(pkey), .is_user(is_user), .acc_type(acc_type),
        .rd_prevent(rd_prevent), .ex_prevent(ex_prevent), .wp_en(wp_en),
        .ukey_en(ukey_en), .skey_en(skey_en),
        .ukey_reg(ukey_reg), .skey_reg(skey_reg),
        .rsp_valid(rsp_valid), .perm_rd(perm_rd), .perm_wr(perm_wr),
        .perm_ex(perm_ex), .allowed(allowed), .fault_key(fault_key),
        .fault_prot(fault_prot)
    );

    // expected {valid, rd, wr, ex, allowed, fkey, fprot}
    function automatic logic [6:0] model();
        bit rd, wr, ex, krd, kwr, hit;
        logic [REG_W-1:0] kr;
        int a;
        int k;
        if (!req_valid) return 7'b0;
        if (is_user && !attr_user) return 7'b1000001;
        rd = !(!is_user && rd_prevent && attr_user);
        wr = rd && (attr_write || (!is_user && !wp_en));
        ex = !attr_nx && (is_user || !(ex_prevent && attr_user));
        if (attr_user) kr = ukey_en ? ukey_reg : '0;
        else           kr = skey_en ? skey_reg : '0;
        krd = 1; kwr = 1;
        k = int'(pkey);
        if (kr != 0) begin
            if (kr[2*k]) begin krd = 0; kwr = 0; end
            else if (kr[2*k+1] && (is_user || wp_en)) kwr = 0;
        end
        a = (acc_type == 2'd0) ? 0 : (acc_type == 2'd1) ? 1 : 2;
        if (kr != 0 && a != 2 && !((a == 0) ? krd : kwr))
            return {1'b1, rd & krd, wr & kwr, ex, 1'b0, 1'b1, 1'b0};
        hit = (a == 0) ? (rd & krd) : (a == 1) ? (wr & kwr) : ex;
        return {1'b1, rd & krd, wr & kwr, ex, hit, 1'b0, !hit};
    endfunction

    task automatic check(input string tag, input logic [6:0] exp);
        logic [6:0] got;
        got = {rsp_valid, perm_rd, perm_wr, perm_ex, allowed, fault_key, fault_prot};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%b expected=%b", tag, got, exp);
        end
    endtask

    // drive at a falling edge, compare at the next falling edge
    task automatic step(input string tag);
        logic [6:0] exp;
        exp = model();
        @(negedge clk);
        check(tag, exp);
    endtask

    task automatic setup(input bit v, input bit au, input bit aw, input bit nx,
                         input bit u, input logic [1:0] acc, input int key);
        req_valid = v; attr_user = au; attr_write = aw; attr_nx = nx;
        is_user = u; acc_type = acc; pkey = KEY_W'(key);
    endtask

    task automatic modes(input bit rp, input bit xp, input bit wp,
                         input bit ue, input bit se);
        rd_prevent = rp; ex_prevent = xp; wp_en = wp; ukey_en = ue; skey_en = se;
    endtask

    initial begin
        #100000;
        bad++;
        total++;
        $display("FAIL watchdog: got=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        setup(1, 1, 1, 0, 1, 2'd0, 0);
        modes(0, 0, 0, 0, 0);
        ukey_reg = '0; skey_reg = '0;
        @(negedge clk); @(negedge clk);
        check("R10 reset", 7'b0);
        rst = 1'b0;

        // R1 user access to supervisor page
        setup(1, 0, 1, 0, 1, 2'd0, 0); step("R1 user on sup page");
        ukey_en = 1; skey_en = 1; skey_reg = '1;
        setup(1, 0, 1, 0, 1, 2'd1, 3); step("R1 user on sup page keys set");
        skey_reg = '0; ukey_en = 0; skey_en = 0;

        // R2 read prevention
        modes(1, 0, 0, 0, 0);
        setup(1, 1, 1, 0, 0, 2'd0, 0); step("R2 sup load user page prevented");
        setup(1, 0, 1, 0, 0, 2'd0, 0); step("R2 sup load sup page");
        setup(1, 1, 1, 0, 1, 2'd0, 0); step("R2 user load unaffected");

        // R3 write rules
        modes(0, 0, 0, 0, 0);
        setup(1, 1, 0, 0, 0, 2'd1, 0); step("R3 sup store ro page wp off");
        wp_en = 1; step("R3 sup store ro page wp on");
        setup(1, 1, 0, 0, 1, 2'd1, 0); step("R3 user store ro page");
        setup(1, 1, 1, 0, 1, 2'd1, 0); step("R3 user store rw page");

        // R4 execute rules
        modes(0, 1, 0, 0, 0);
        setup(1, 1, 1, 0, 0, 2'd2, 0); step("R4 sup fetch user page prevented");
        setup(1, 1, 1, 0, 1, 2'd2, 0); step("R4 user fetch user page");
        setup(1, 0, 1, 1, 0, 2'd2, 0); step("R4 nx fetch");
        setup(1, 1, 1, 0, 0, 2'd3, 0); step("R8 code 3 as fetch");

        // R5 key register selection
        modes(0, 0, 1, 0, 1);
        ukey_reg = 32'h0000_0001 << 10; skey_reg = '0;
        setup(1, 1, 1, 0, 1, 2'd0, 5); step("R5 user key disabled");
        ukey_en = 1; step("R5 user key enabled AD");
        skey_reg = 32'h0000_0001 << 10; ukey_en = 0;
        setup(1, 0, 1, 0, 0, 2'd0, 5); step("R5 sup key enabled AD");
        skey_en = 0; step("R5 sup key disabled");

        // R6 write-disable and wp
        modes(0, 0, 0, 0, 1);
        skey_reg = 32'h0000_0002 << 6;
        setup(1, 0, 1, 0, 0, 2'd1, 3); step("R6 sup WD wp off");
        wp_en = 1; step("R6 sup WD wp on");
        setup(1, 0, 1, 0, 0, 2'd0, 3); step("R6 sup WD load");
        setup(1, 0, 1, 0, 0, 2'd2, 3); step("R8 fetch with key");
        skey_reg = 32'h0000_0001 << 6;
        setup(1, 0, 1, 0, 0, 2'd2, 3); step("R8 fetch AD no key fault");

        // R7 key fault wins over page fault
        modes(0, 0, 1, 1, 0);
        ukey_reg = 32'h0000_0002 << 4;
        setup(1, 1, 0, 0, 1, 2'd1, 2); step("R7 WD and ro page");
        modes(1, 0, 0, 1, 0);
        ukey_reg = 32'h0000_0001 << 4;
        setup(1, 1, 1, 0, 0, 2'd0, 2); step("R7 AD and read prevention");

        // R9 merged permissions, other key unaffected
        setup(1, 1, 1, 0, 1, 2'd1, 7); step("R9 other key unaffected");

        // R10 idle
        setup(0, 1, 1, 0, 1, 2'd0, 0); step("R10 idle");
        setup(1, 1, 1, 0, 1, 2'd0, 0); step("R10 after idle");

        // R9 broad sweep compared on every clock
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            setup(r[0] | r[1], r[2], r[3], r[4], r[5], r[7:6], int'(r[11:8]));
            modes(r[12], r[13], r[14], r[15], r[16]);
            if (r[20:17] == 0) begin ukey_reg = '0; skey_reg = '0; end
            else begin ukey_reg = $urandom & $urandom; skey_reg = $urandom & $urandom; end
            step("R9 sweep");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule